// File: doc/BRIEF.md
# Dual-Port Audio Serial Clock Generator

This block acts as clock master for two audio serial ports. For each port it produces a bit clock and a frame clock as registered square waves in the master clock domain. It also produces two single-cycle pulses: one marks each bit clock falling edge and one marks each frame clock edge. Each port has its own clock-rate setting, made of a 3-bit prescale code and a 2-bit speed code. The frame clock always runs at 1/64 of the bit clock, so one frame spans 64 bit periods: 32 with the frame clock low, then 32 with it high.

Port 1 always runs from master clock 1. A source-select input chooses the clock for port 2. With select low, port 2 shares master clock 1. With select high, it runs from master clock 2. The block builds both the prescale and the speed division from one fractional accumulator per port. This lets the divide-by-1.5 setting work without a gated clock or dual-edge logic. When a port's setting changes, that port restarts from a clean state. Settings that are reserved or too fast to produce hold the port's outputs low and raise that port's invalid flag.

Top module: `aclk_dual_master`

## Requirements
- R1: While reset is asserted, every bit clock, frame clock and pulse output is low and both invalid flags are low.
- R2: The prescale code sets a factor N: 000 gives 1, 001 gives 1.5, 010 gives 2, 011 gives 3 and 100 gives 4.
- R3: The speed code sets a factor S: 00 gives 4, 01 gives 2 and 10 gives 1. The bit clock period is N*S master clock cycles.
- R4: With N=1.5 and S=2, the bit clock is high for 1 cycle and low for 2 cycles in every period.
- R5: The frame clock period is 64 bit clock periods, split into 32 low and 32 high. After a restart the frame clock begins low.
- R6: The frame clock changes only together with a bit clock falling edge. The frame pulse is high for exactly the one cycle in which the frame clock has just changed.
- R7: The fall pulse is high for exactly the one cycle in which the bit clock has just fallen, giving 32 pulses per frame half.
- R8: Prescale codes 101 to 111, speed code 11, and the pairs (000,10) and (001,10) are invalid. An invalid setting holds that port's bit clock, frame clock and pulses low and raises its invalid flag.
- R9: A change to a port's setting clears that port's bit clock and frame clock to low one clock edge later. The port then runs at the new rate.
- R10: With the source select low, port 2 is timed by master clock 1. With the source select high, port 2 is timed by master clock 2.
- R11: The two ports run at independent rates from their own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk1_i | input | 1 | Master clock 1 |
| mclk2_i | input | 1 | Master clock 2 |
| rst_ni | input | 1 | Asynchronous active-low reset |
| async_i | input | 1 | Port 2 source select: 0 uses master clock 1, 1 uses master clock 2 |
| p1_pre_i | input | 3 | Port 1 prescale code |
| p1_spd_i | input | 2 | Port 1 speed code |
| p2_pre_i | input | 3 | Port 2 prescale code |
| p2_spd_i | input | 2 | Port 2 speed code |
| p1_sclk_o | output | 1 | Port 1 bit clock |
| p1_lrck_o | output | 1 | Port 1 frame clock |
| p1_fall_o | output | 1 | Port 1 bit clock fall pulse |
| p1_fedge_o | output | 1 | Port 1 frame clock edge pulse |
| p1_bad_o | output | 1 | Port 1 invalid setting flag |
| p2_sclk_o | output | 1 | Port 2 bit clock |
| p2_lrck_o | output | 1 | Port 2 frame clock |
| p2_fall_o | output | 1 | Port 2 bit clock fall pulse |
| p2_fedge_o | output | 1 | Port 2 frame clock edge pulse |
| p2_bad_o | output | 1 | Port 2 invalid setting flag |

## Verification
The assertions check, on every cycle of each port, these cycle-local relations:
- the fall pulse coincides with a bit clock drop;
- the frame pulse coincides with a frame clock change;
- a rising frame clock comes together with a bit clock fall;
- an invalid setting keeps every output low.

Some behaviours span many cycles and only the bench scenarios can show them. These are the periods for each code pair, the uneven 1-and-2 pattern of the 1.5 divide, the 32/32 frame split, the restart after a setting change, the choice of source clock for port 2, and the independence of the two ports.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;
  localparam int PRE_W = 3;
  localparam int SPD_W = 2;
  localparam int TQ_W  = 6;
  // accumulator step, in quarter master-clock cycles per cycle
  localparam int QSTEP = 4;

  // twice the prescale factor, 0 when reserved
  function automatic logic [3:0] pre_halves(input logic [PRE_W-1:0] code);
    case (code)
      3'd0:    return 4'd2;
      3'd1:    return 4'd3;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  // speed divide ratio, 0 when reserved
  function automatic logic [2:0] spd_ratio(input logic [SPD_W-1:0] code);
    case (code)
      2'd0:    return 3'd4;
      2'd1:    return 3'd2;
      2'd2:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // half bit period in quarter master-clock cycles
  function automatic logic [TQ_W-1:0] toggle_quarters(input logic [PRE_W-1:0] pre,
                                                      input logic [SPD_W-1:0] spd);
    logic [TQ_W-1:0] a;
    logic [TQ_W-1:0] b;
    a = TQ_W'(pre_halves(pre));
    b = TQ_W'(spd_ratio(spd));
    return a * b;
  endfunction
endpackage

// File: rtl/aclk_rst_sync.sv
`timescale 1ns/1ps
module aclk_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/aclk_rate_acc.sv
`timescale 1ns/1ps
module aclk_rate_acc #(
  parameter int TQ_W = 6,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic [TQ_W-1:0] tq,
  output logic            tick
);
  localparam int ACC_W = TQ_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] sum;

  always_comb begin
    sum   = acc_q + ACC_W'(STEP);
    acc_d = acc_q;
    tick  = 1'b0;
    if (clr) begin
      acc_d = '0;
    end else if (run) begin
      if (sum >= {1'b0, tq}) begin
        tick  = 1'b1;
        acc_d = sum - {1'b0, tq};
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/aclk_port.sv
`timescale 1ns/1ps
module aclk_port
  import aclk_pkg::*;
#(
  parameter int SLOTS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [SPD_W-1:0] spd_i,
  output logic             sclk_o,
  output logic             lrck_o,
  output logic             fall_o,
  output logic             fedge_o,
  output logic             bad_o
);
  localparam int HALF  = SLOTS / 2;
  localparam int CNT_W = $clog2(HALF);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(HALF - 1);
  localparam logic [TQ_W-1:0]  TQ_MIN = TQ_W'(QSTEP);

  logic [PRE_W-1:0] pre_q;
  logic [SPD_W-1:0] spd_q;
  logic [TQ_W-1:0]  tq;
  logic             cfg_ok;
  logic             cfg_chg;
  logic             tick;

  logic             sclk_q, sclk_d;
  logic             lrck_q, lrck_d;
  logic             fall_q, fall_d;
  logic             fedge_q, fedge_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tq      = toggle_quarters(pre_q, spd_q);
  assign cfg_ok  = (tq >= TQ_MIN);
  assign cfg_chg = (pre_i != pre_q) || (spd_i != spd_q);

  aclk_rate_acc #(.TQ_W(TQ_W), .STEP(QSTEP)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cfg_chg),
    .run  (cfg_ok),
    .tq   (tq),
    .tick (tick)
  );

  always_comb begin
    sclk_d  = sclk_q;
    lrck_d  = lrck_q;
    cnt_d   = cnt_q;
    fall_d  = 1'b0;
    fedge_d = 1'b0;
    if (cfg_chg) begin
      sclk_d = 1'b0;
      lrck_d = 1'b0;
      cnt_d  = '0;
    end else if (tick) begin
      sclk_d = ~sclk_q;
      if (sclk_q) begin
        fall_d = 1'b1;
        if (cnt_q == LAST) begin
          cnt_d   = '0;
          lrck_d  = ~lrck_q;
          fedge_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      spd_q   <= '0;
      sclk_q  <= 1'b0;
      lrck_q  <= 1'b0;
      fall_q  <= 1'b0;
      fedge_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pre_q   <= pre_i;
      spd_q   <= spd_i;
      sclk_q  <= sclk_d;
      lrck_q  <= lrck_d;
      fall_q  <= fall_d;
      fedge_q <= fedge_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign lrck_o  = lrck_q;
  assign fall_o  = fall_q;
  assign fedge_o = fedge_q;
  assign bad_o   = ~cfg_ok;
endmodule

// File: rtl/aclk_dual_master.sv
`timescale 1ns/1ps
module aclk_dual_master
  import aclk_pkg::*;
#(
  parameter int SLOTS = 64
) (
  input  logic             mclk1_i,
  input  logic             mclk2_i,
  input  logic             rst_ni,
  input  logic             async_i,
  input  logic [PRE_W-1:0] p1_pre_i,
  input  logic [SPD_W-1:0] p1_spd_i,
  input  logic [PRE_W-1:0] p2_pre_i,
  input  logic [SPD_W-1:0] p2_spd_i,
  output logic             p1_sclk_o,
  output logic             p1_lrck_o,
  output logic             p1_fall_o,
  output logic             p1_fedge_o,
  output logic             p1_bad_o,
  output logic             p2_sclk_o,
  output logic             p2_lrck_o,
  output logic             p2_fall_o,
  output logic             p2_fedge_o,
  output logic             p2_bad_o
);
  localparam int NP = 2;

  logic             p2_clk;
  logic             pclk   [NP];
  logic             prst_n [NP];
  logic [PRE_W-1:0] pre    [NP];
  logic [SPD_W-1:0] spd    [NP];
  logic             sclk   [NP];
  logic             lrck   [NP];
  logic             fall   [NP];
  logic             fedge  [NP];
  logic             bad    [NP];

  // port 2 source clock select; a glitch-free clock mux cell goes here
  assign p2_clk  = async_i ? mclk2_i : mclk1_i;
  assign pclk[0] = mclk1_i;
  assign pclk[1] = p2_clk;
  assign pre[0]  = p1_pre_i;
  assign pre[1]  = p2_pre_i;
  assign spd[0]  = p1_spd_i;
  assign spd[1]  = p2_spd_i;

  for (genvar g = 0; g < NP; g++) begin : g_port
    aclk_rst_sync u_rst (
      .clk   (pclk[g]),
      .rst_ni(rst_ni),
      .rst_no(prst_n[g])
    );

    aclk_port #(.SLOTS(SLOTS)) u_port (
      .clk    (pclk[g]),
      .rst_n  (prst_n[g]),
      .pre_i  (pre[g]),
      .spd_i  (spd[g]),
      .sclk_o (sclk[g]),
      .lrck_o (lrck[g]),
      .fall_o (fall[g]),
      .fedge_o(fedge[g]),
      .bad_o  (bad[g])
    );
  end

  assign p1_sclk_o  = sclk[0];
  assign p1_lrck_o  = lrck[0];
  assign p1_fall_o  = fall[0];
  assign p1_fedge_o = fedge[0];
  assign p1_bad_o   = bad[0];
  assign p2_sclk_o  = sclk[1];
  assign p2_lrck_o  = lrck[1];
  assign p2_fall_o  = fall[1];
  assign p2_fedge_o = fedge[1];
  assign p2_bad_o   = bad[1];
endmodule

// File: rtl/aclk_dual_master_chk.sv
`timescale 1ns/1ps
module aclk_dual_master_chk (
  input logic clk1,
  input logic clk2,
  input logic rst_n,
  input logic p1_sclk,
  input logic p1_lrck,
  input logic p1_fall,
  input logic p1_fedge,
  input logic p1_bad,
  input logic p2_sclk,
  input logic p2_lrck,
  input logic p2_fall,
  input logic p2_fedge,
  input logic p2_bad
);
  // R7: fall pulse marks the cycle right after the bit clock dropped
  p_fall_pulse_r7: assert property (@(posedge clk1) disable iff (!rst_n)
    p1_fall |-> (!p1_sclk && $past(p1_sclk)));
  p_fall_pulse_p2_r7: assert property (@(posedge clk2) disable iff (!rst_n)
    p2_fall |-> (!p2_sclk && $past(p2_sclk)));

  // R6: frame pulse marks a frame clock change
  p_frame_pulse_r6: assert property (@(posedge clk1) disable iff (!rst_n)
    p1_fedge |-> (p1_lrck != $past(p1_lrck)));
  p_frame_pulse_p2_r6: assert property (@(posedge clk2) disable iff (!rst_n)
    p2_fedge |-> (p2_lrck != $past(p2_lrck)));

  // R6: frame clock rises only together with a bit clock fall
  p_lrck_rise_on_fall_r6: assert property (@(posedge clk1) disable iff (!rst_n)
    $rose(p1_lrck) |-> p1_fall);
  p_lrck_rise_on_fall_p2_r6: assert property (@(posedge clk2) disable iff (!rst_n)
    $rose(p2_lrck) |-> p2_fall);

  // R8: an invalid setting keeps the port silent
  p_hold_low_r8: assert property (@(posedge clk1) disable iff (!rst_n)
    p1_bad |-> (!p1_sclk && !p1_lrck && !p1_fall && !p1_fedge));
  p_hold_low_p2_r8: assert property (@(posedge clk2) disable iff (!rst_n)
    p2_bad |-> (!p2_sclk && !p2_lrck && !p2_fall && !p2_fedge));
endmodule

bind aclk_dual_master aclk_dual_master_chk u_chk (
  .clk1    (mclk1_i),
  .clk2    (p2_clk),
  .rst_n   (rst_ni),
  .p1_sclk (p1_sclk_o),
  .p1_lrck (p1_lrck_o),
  .p1_fall (p1_fall_o),
  .p1_fedge(p1_fedge_o),
  .p1_bad  (p1_bad_o),
  .p2_sclk (p2_sclk_o),
  .p2_lrck (p2_lrck_o),
  .p2_fall (p2_fall_o),
  .p2_fedge(p2_fedge_o),
  .p2_bad  (p2_bad_o)
);

// File: tb/aclk_dual_master_bench.sv
`timescale 1ns/1ps
module aclk_dual_master_bench;
  logic       mclk1 = 1'b0;
  logic       mclk2 = 1'b0;
  logic       rst_n = 1'b0;
  logic       async_sel = 1'b0;
  logic [2:0] p1_pre = 3'd0;
  logic [1:0] p1_spd = 2'd0;
  logic [2:0] p2_pre = 3'd2;
  logic [1:0] p2_spd = 2'd2;
  logic p1_sclk, p1_lrck, p1_fall, p1_fedge, p1_bad;
  logic p2_sclk, p2_lrck, p2_fall, p2_fedge, p2_bad;

  int n_chk = 0;
  int n_err = 0;

  always #5 mclk1 = ~mclk1;
  always #7 mclk2 = ~mclk2;

  aclk_dual_master u_aclk_dual_master (
    .mclk1_i(mclk1), .mclk2_i(mclk2), .rst_ni(rst_n), .async_i(async_sel),
    .p1_pre_i(p1_pre), .p1_spd_i(p1_spd), .p2_pre_i(p2_pre), .p2_spd_i(p2_spd),
    .p1_sclk_o(p1_sclk), .p1_lrck_o(p1_lrck), .p1_fall_o(p1_fall),
    .p1_fedge_o(p1_fedge), .p1_bad_o(p1_bad),
    .p2_sclk_o(p2_sclk), .p2_lrck_o(p2_lrck), .p2_fall_o(p2_fall),
    .p2_fedge_o(p2_fedge), .p2_bad_o(p2_bad)
  );

  // {prescale code, speed code, bit period in master clock cycles}
  localparam logic [12:0] VEC [11] = '{
    {3'd0, 2'd0, 8'd4},  {3'd0, 2'd1, 8'd2},  {3'd1, 2'd0, 8'd6},
    {3'd1, 2'd1, 8'd3},  {3'd2, 2'd0, 8'd8},  {3'd2, 2'd1, 8'd4},
    {3'd2, 2'd2, 8'd2},  {3'd3, 2'd0, 8'd12}, {3'd3, 2'd2, 8'd3},
    {3'd4, 2'd0, 8'd16}, {3'd4, 2'd2, 8'd4}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_p1(input logic [2:0] pre, input logic [1:0] spd);
    @(negedge mclk1);
    p1_pre = pre;
    p1_spd = spd;
  endtask

  task automatic period_p1(output longint p);
    time t0;
    @(posedge p1_sclk);
    @(posedge p1_sclk);
    t0 = $time;
    @(posedge p1_sclk);
    p = longint'($time - t0);
  endtask

  task automatic period_p2(output longint p);
    time t0;
    @(posedge p2_sclk);
    @(posedge p2_sclk);
    t0 = $time;
    @(posedge p2_sclk);
    p = longint'($time - t0);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    longint p;
    time    t0;
    int     cnt;

    // R1: reset state
    repeat (4) @(negedge mclk1);
    check({p1_sclk, p1_lrck, p1_fall, p1_fedge, p1_bad,
           p2_sclk, p2_lrck, p2_fall, p2_fedge, p2_bad} == 10'd0, "R1 outputs in reset",
          {p1_sclk, p1_lrck, p1_fall, p1_fedge, p1_bad,
           p2_sclk, p2_lrck, p2_fall, p2_fedge, p2_bad}, 0);
    @(negedge mclk1);
    rst_n = 1'b1;

    // R2 R3: bit period for each code pair on port 1
    for (int i = 0; i < 11; i++) begin
      set_p1(VEC[i][12:10], VEC[i][9:8]);
      period_p1(p);
      check(p == 10 * longint'(VEC[i][7:0]), $sformatf("R2 R3 period pre=%0d spd=%0d",
            VEC[i][12:10], VEC[i][9:8]), p, 10 * longint'(VEC[i][7:0]));
    end

    // R4: 1.5 divide with S=2, high 1 cycle, low 2 cycles
    set_p1(3'd1, 2'd1);
    repeat (3) @(posedge p1_sclk);
    t0 = $time;
    @(negedge p1_sclk);
    check(($time - t0) == 10, "R4 high time", longint'($time - t0), 10);
    t0 = $time;
    @(posedge p1_sclk);
    check(($time - t0) == 20, "R4 low time", longint'($time - t0), 20);

    // R5: frame starts low and has 32/32 split, bit period 20 ns
    set_p1(3'd2, 2'd2);
    @(negedge mclk1);
    check(p1_lrck == 1'b0, "R5 frame low after restart", p1_lrck, 0);
    @(posedge p1_lrck);
    t0 = $time;
    @(negedge mclk1);
    check(p1_fedge == 1'b1, "R6 frame pulse", p1_fedge, 1);
    check(p1_sclk == 1'b0 && p1_fall == 1'b1, "R6 frame edge on bit fall",
          {p1_sclk, p1_fall}, 1);
    // R7: 32 fall pulses across the high half (the rising one counted above)
    cnt = 0;
    while (p1_lrck == 1'b1) begin
      @(negedge mclk1);
      if (p1_fall) cnt++;
    end
    check(cnt == 32, "R7 fall pulses per half", cnt, 32);
    check(($time - t0) <= 650 && ($time - t0) >= 640, "R5 high half",
          longint'($time - t0), 640);
    @(posedge p1_lrck);
    check(($time - t0) == 1280, "R5 frame period", longint'($time - t0), 1280);

    // R8: invalid settings hold outputs low
    set_p1(3'd5, 2'd0);
    repeat (2) @(negedge mclk1);
    check(p1_bad == 1'b1, "R8 flag reserved prescale", p1_bad, 1);
    cnt = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge mclk1);
      if (p1_sclk || p1_lrck || p1_fall || p1_fedge) cnt++;
    end
    check(cnt == 0, "R8 outputs held low", cnt, 0);
    set_p1(3'd2, 2'd3);
    repeat (2) @(negedge mclk1);
    check(p1_bad == 1'b1, "R8 flag reserved speed", p1_bad, 1);
    set_p1(3'd0, 2'd2);
    repeat (2) @(negedge mclk1);
    check(p1_bad == 1'b1, "R8 flag too fast 000/10", p1_bad, 1);
    set_p1(3'd1, 2'd2);
    repeat (2) @(negedge mclk1);
    check(p1_bad == 1'b1 && p1_sclk == 1'b0, "R8 flag too fast 001/10", p1_bad, 1);
    set_p1(3'd2, 2'd0);
    repeat (2) @(negedge mclk1);
    check(p1_bad == 1'b0, "R8 flag clears on valid", p1_bad, 0);

    // R9: change while both clocks high
    set_p1(3'd3, 2'd0);
    @(posedge p1_lrck);
    @(posedge p1_sclk);
    set_p1(3'd2, 2'd0);
    @(negedge mclk1);
    check(p1_sclk == 1'b0 && p1_lrck == 1'b0, "R9 restart clears clocks",
          {p1_sclk, p1_lrck}, 0);
    period_p1(p);
    check(p == 80, "R9 new rate", p, 80);

    // R11: both ports at different rates together
    set_p1(3'd4, 2'd0);
    @(negedge mclk1);
    p2_pre = 3'd0;
    p2_spd = 2'd1;
    period_p1(p);
    check(p == 160, "R11 port 1 rate", p, 160);
    period_p2(p);
    check(p == 20, "R11 port 2 rate", p, 20);

    // R10: port 2 source select, changed only under reset
    @(negedge mclk1);
    rst_n = 1'b0;
    p2_pre = 3'd2;
    p2_spd = 2'd2;
    async_sel = 1'b1;
    repeat (3) @(negedge mclk1);
    rst_n = 1'b1;
    period_p2(p);
    check(p == 28, "R10 port 2 on clock 2", p, 28);
    @(negedge mclk1);
    rst_n = 1'b0;
    async_sel = 1'b0;
    repeat (3) @(negedge mclk1);
    rst_n = 1'b1;
    period_p2(p);
    check(p == 20, "R10 port 2 on clock 1", p, 20);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule